// File: doc/BRIEF.md
# ECC Write Fault Injector

This block sits between a memory controller's write port (data plus the check bits produced by its SECDED encoder) and the RAM array. When a write hits one programmed word address while injection is armed, the block inverts a programmable set of bits in the 72-bit stored word. Because the inversion happens after the check bits are computed, the RAM ends up holding a real data/check mismatch. Software uses this to plant one-bit or two-bit faults and then exercise the correction and detection logic on the read side.

Configuration has two layers. Configuration writes land in a shadow set: target address, data flip mask, check flip mask, arm bit. The shadow set does not steer writes. A synchronising read of the busy flag (`sync_rd`) copies the shadow set into a staging copy. After a fixed transfer window the staging copy is committed to the active set, and only the active set governs injection. A small FSM controls this. In `FI_IDLE`, no change is pending. A configuration write takes `FI_IDLE` to `FI_PENDING`. A sync read takes `FI_PENDING` to `FI_XFER`. `FI_XFER` lasts `SYNC_CYCLES` cycles, and `sync_busy` is high for all of them. At the end, `FI_XFER` goes to `FI_IDLE` and the staged set is committed. If a configuration write arrived during the transfer, or on the same cycle as the sync read, `FI_XFER` goes to `FI_PENDING` instead, so a further sync read is needed. A sync read in `FI_IDLE` does nothing.

Top module: `ecc_flt_inject`

## Requirements
- R1: After reset, `sync_busy` is 0, injection is disarmed and every write passes through unchanged.
- R2: A write whose `wr_addr` differs from the active target address is stored unchanged, with `mem_wdata` = {`wr_chk`, `wr_data`}.
- R3: A write to the active target address while armed, with all of `wr_be` set, is stored as {`wr_chk`, `wr_data`} XOR the active mask. Mask bits 63:0 map to data bits and mask bits 71:64 map to check bits.
- R4: While the active arm bit is 0, no write is altered, even at the target address.
- R5: On a matching armed write, data mask bits in byte b (bits 8b+7..8b) take effect only if `wr_be[b]` is 1. Check mask bits take effect only if all eight byte enables are 1. Bytes whose enable is 0 pass unchanged.
- R6: Configuration writes (`cfg_sel` 0 = address from `cfg_wdata[ADDR_W-1:0]`, 1 = data mask, 2 = check mask from `cfg_wdata[7:0]`, 3 = arm bit `cfg_wdata[0]`) have no effect on stored words until the transfer that follows a sync read has completed, including during the busy window.
- R7: A sync read while a change is pending holds `sync_busy` at 1 for exactly `SYNC_CYCLES` (default 3) cycles starting at the next clock edge. The new configuration governs writes once `sync_busy` returns to 0.
- R8: A sync read with no pending change leaves `sync_busy` at 0.
- R9: A configuration write made during a transfer is not part of that transfer. It takes effect only after a later sync read completes.
- R10: `mem_we` and `mem_addr` follow `wr_en` and `wr_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | DATA_W | Configuration write data |
| sync_rd | input | 1 | Read strobe of the busy flag (synchronising read) |
| sync_busy | output | 1 | Busy flag, 1 while a configuration transfer runs |
| wr_en | input | 1 | Write request from the controller |
| wr_addr | input | ADDR_W | Write word address |
| wr_be | input | DATA_W/8 | Byte enables of the write |
| wr_data | input | DATA_W | Write data |
| wr_chk | input | CHK_W | Check bits from the encoder |
| mem_we | output | 1 | Write strobe to the RAM |
| mem_addr | output | ADDR_W | Word address to the RAM |
| mem_wdata | output | DATA_W+CHK_W | Stored word {check, data}, faults applied |

## Verification
The assertions check several rules on every cycle. Unmasked bytes pass through unchanged. A disarmed or non-matching write is never altered. The RAM strobe and address mirror the request. The active configuration can change only on the cycle that ends a busy window. No busy window lasts longer than `SYNC_CYCLES` cycles. Some behaviour only the bench scenarios can show: the exact flipped pattern for each byte-enable combination, the exact length of the busy window, and the deferral of a configuration write made mid-transfer until a second sync read.

// File: rtl/ecc_fi_pkg.sv
package ecc_fi_pkg;

    // Transfer controller states
    typedef enum logic [1:0] {
        FI_IDLE    = 2'd0,
        FI_PENDING = 2'd1,
        FI_XFER    = 2'd2
    } fi_state_e;

    // Configuration register select codes
    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_DMASK = 2'd1,
        SEL_CMASK = 2'd2,
        SEL_CTRL  = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/ecc_fi_cfg_regs.sv
module ecc_fi_cfg_regs
    import ecc_fi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    localparam int TOT_W = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] sh_addr,
    output logic [TOT_W-1:0]  sh_mask,
    output logic              sh_en
);

    // Shadow set: written by software, not yet visible to the write path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_addr <= '0;
            sh_mask <= '0;
            sh_en   <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                SEL_ADDR:  sh_addr                 <= cfg_wdata[ADDR_W-1:0];
                SEL_DMASK: sh_mask[DATA_W-1:0]     <= cfg_wdata;
                SEL_CMASK: sh_mask[TOT_W-1:DATA_W] <= cfg_wdata[CHK_W-1:0];
                SEL_CTRL:  sh_en                   <= cfg_wdata[0];
            endcase
        end
    end

endmodule

// File: rtl/ecc_fi_sync_fsm.sv
module ecc_fi_sync_fsm
    import ecc_fi_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int TOT_W       = 72,
    parameter int SYNC_CYCLES = 3,
    localparam int CNT_W      = $clog2(SYNC_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              sync_rd,
    input  logic [ADDR_W-1:0] sh_addr,
    input  logic [TOT_W-1:0]  sh_mask,
    input  logic              sh_en,
    output logic [ADDR_W-1:0] act_addr,
    output logic [TOT_W-1:0]  act_mask,
    output logic              act_en,
    output logic              sync_busy
);

    fi_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              dirty_q;
    logic [ADDR_W-1:0] stg_addr;
    logic [TOT_W-1:0]  stg_mask;
    logic              stg_en;
    logic              start_xfer;
    logic              commit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FI_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FI_IDLE:    if (cfg_we)  state_d = FI_PENDING;
            FI_PENDING: if (sync_rd) state_d = FI_XFER;
            FI_XFER:    if (cnt_q == '0)
                            state_d = (dirty_q || cfg_we) ? FI_PENDING : FI_IDLE;
            default:    state_d = FI_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        start_xfer = 1'b0;
        commit     = 1'b0;
        sync_busy  = 1'b0;
        unique case (state_q)
            FI_IDLE:    ;
            FI_PENDING: start_xfer = sync_rd;
            FI_XFER: begin
                sync_busy = 1'b1;
                commit    = (cnt_q == '0);
            end
            default:    ;
        endcase
    end

    // Transfer timer and re-pend flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            dirty_q <= 1'b0;
        end else begin
            if (start_xfer)                  cnt_q <= CNT_W'(SYNC_CYCLES - 1);
            else if (sync_busy && cnt_q != '0) cnt_q <= cnt_q - 1'b1;

            if (start_xfer)                  dirty_q <= cfg_we;
            else if (commit)                 dirty_q <= 1'b0;
            else if (sync_busy && cfg_we)    dirty_q <= 1'b1;
        end
    end

    // Staging snapshot at transfer start, active set at transfer end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_addr <= '0;
            stg_mask <= '0;
            stg_en   <= 1'b0;
            act_addr <= '0;
            act_mask <= '0;
            act_en   <= 1'b0;
        end else begin
            if (start_xfer) begin
                stg_addr <= sh_addr;
                stg_mask <= sh_mask;
                stg_en   <= sh_en;
            end
            if (commit) begin
                act_addr <= stg_addr;
                act_mask <= stg_mask;
                act_en   <= stg_en;
            end
        end
    end

    // Checker: consecutive busy cycles seen so far
    logic [CNT_W:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (sync_busy) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_busy |-> (run_q < (CNT_W+1)'(SYNC_CYCLES)));

    assert_active_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sync_busy) |-> $stable({act_en, act_addr, act_mask}));

    assert_idle_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FI_IDLE && sync_rd) |=> !sync_busy);

endmodule

// File: rtl/ecc_fi_flip.sv
module ecc_fi_flip #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    localparam int BYTES = DATA_W / 8,
    localparam int TOT_W = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CHK_W-1:0]  wr_chk,
    input  logic [ADDR_W-1:0] act_addr,
    input  logic [TOT_W-1:0]  act_mask,
    input  logic              act_en,
    output logic [TOT_W-1:0]  st_word
);

    logic             hit;
    logic [TOT_W-1:0] eff_mask;
    logic [TOT_W-1:0] raw_word;

    assign raw_word = {wr_chk, wr_data};
    assign hit      = wr_en && act_en && (wr_addr == act_addr);

    // Per-byte gating of the data part of the flip mask
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign eff_mask[b*8 +: 8] = act_mask[b*8 +: 8] & {8{wr_be[b]}};

        assert_masked_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_be[b]) |-> (st_word[b*8 +: 8] == wr_data[b*8 +: 8]));
    end

    // Check bits change only on a full-word write
    assign eff_mask[TOT_W-1:DATA_W] = act_mask[TOT_W-1:DATA_W] & {CHK_W{&wr_be}};

    assign st_word = hit ? (raw_word ^ eff_mask) : raw_word;

endmodule

// File: rtl/ecc_flt_inject.sv
module ecc_flt_inject #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 64,
    parameter int CHK_W       = 8,
    parameter int SYNC_CYCLES = 3,
    localparam int BYTES      = DATA_W / 8,
    localparam int TOT_W      = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              sync_rd,
    output logic              sync_busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CHK_W-1:0]  wr_chk,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [TOT_W-1:0]  mem_wdata
);

    logic [ADDR_W-1:0] sh_addr, act_addr;
    logic [TOT_W-1:0]  sh_mask, act_mask;
    logic              sh_en, act_en;

    ecc_fi_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .sh_addr(sh_addr), .sh_mask(sh_mask), .sh_en(sh_en)
    );

    ecc_fi_sync_fsm #(
        .ADDR_W(ADDR_W), .TOT_W(TOT_W), .SYNC_CYCLES(SYNC_CYCLES)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .sync_rd(sync_rd),
        .sh_addr(sh_addr), .sh_mask(sh_mask), .sh_en(sh_en),
        .act_addr(act_addr), .act_mask(act_mask), .act_en(act_en),
        .sync_busy(sync_busy)
    );

    ecc_fi_flip #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W)
    ) u_flip (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .wr_chk(wr_chk),
        .act_addr(act_addr), .act_mask(act_mask), .act_en(act_en),
        .st_word(mem_wdata)
    );

    assign mem_we   = wr_en;
    assign mem_addr = wr_addr;

    assert_addr_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr == wr_addr) && (mem_we == wr_en));

    assert_no_inject_disarmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |-> (mem_wdata == {wr_chk, wr_data}));

    assert_miss_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr != act_addr) |-> (mem_wdata == {wr_chk, wr_data}));

endmodule

// File: tb/ecc_flt_inject_tb.sv
module ecc_flt_inject_tb_top;

    localparam int AW = 12;
    localparam int DW = 64;
    localparam int CW = 8;
    localparam int SC = 3;

    localparam logic [63:0] D    = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] DMSK = 64'h1000_0000_0000_0020;
    localparam logic [71:0] FULL = {8'h5B, 64'h1123_4567_89AB_CDCF};
    localparam logic [71:0] PASS = {8'h5A, D};

    // {addr[12], be[8], data[64], chk[8], expected[72]}
    localparam int NV = 6;
    localparam logic [163:0] VEC [NV] = '{
        {12'h02A, 8'hFF, D, 8'h5A, FULL},                                  // R3 full hit
        {12'h02B, 8'hFF, D, 8'h5A, PASS},                                  // R2 miss
        {12'h02A, 8'h01, D, 8'h5A, {8'h5A, 64'h0123_4567_89AB_CDCF}},      // R5 low byte
        {12'h02A, 8'h80, D, 8'h5A, {8'h5A, 64'h1123_4567_89AB_CDEF}},      // R5 top byte
        {12'h02A, 8'h7E, D, 8'h5A, PASS},                                  // R5 no covered bit
        {12'h000, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00,
                         {8'h00, 64'hFFFF_FFFF_FFFF_FFFF}}                 // R2 miss
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          sync_rd = 1'b0;
    logic          sync_busy;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_be = '0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] wr_chk = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [71:0]   mem_wdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ecc_flt_inject #(.ADDR_W(AW), .DATA_W(DW), .CHK_W(CW), .SYNC_CYCLES(SC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .sync_rd(sync_rd), .sync_busy(sync_busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .wr_chk(wr_chk),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [63:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive a write at the current negedge and return the stored word
    task automatic do_wr(input logic [11:0] a, input logic [7:0] be,
                         input logic [63:0] d, input logic [7:0] c,
                         output logic [71:0] w);
        wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d; wr_chk = c;
        #1;
        w = mem_wdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        #1;
        while (sync_busy && n < 20) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic sync_pulse();
        @(negedge clk);
        sync_rd = 1'b1;
        @(negedge clk);
        sync_rd = 1'b0;
    endtask

    initial begin
        #(200_000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [71:0] w;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        #1;
        check("R1 busy", {71'd0, sync_busy}, 72'd0);
        do_wr(12'h000, 8'hFF, D, 8'h5A, w);
        check("R1 passthrough", w, PASS);

        // Program shadow set; no effect before sync (R6)
        cfg_write(2'd0, 64'h2A);
        cfg_write(2'd1, DMSK);
        cfg_write(2'd2, 64'h01);
        cfg_write(2'd3, 64'h1);
        #1;
        check("R6 busy before sync", {71'd0, sync_busy}, 72'd0);
        do_wr(12'h02A, 8'hFF, D, 8'h5A, w);
        check("R6 not yet active", w, PASS);

        // R7: busy window length, R6: old config during busy
        sync_pulse();
        do_wr(12'h02A, 8'hFF, D, 8'h5A, w);
        check("R6 during busy", w, PASS);
        wait_idle(n);
        check("R7 busy cycles", 72'(n), 72'(SC));

        // Table walk: R2 R3 R5 R10
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            do_wr(VEC[i][163:152], VEC[i][151:144], VEC[i][143:80], VEC[i][79:72], w);
            check($sformatf("R3/R5/R2 vector %0d", i), w, VEC[i][71:0]);
            check($sformatf("R10 vector %0d", i), {59'd0, mem_we, mem_addr},
                  {59'd0, 1'b1, VEC[i][163:152]});
        end
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R10 idle strobe", {71'd0, mem_we}, 72'd0);

        // R8: sync read with nothing pending
        sync_pulse();
        #1;
        check("R8 busy stays low", {71'd0, sync_busy}, 72'd0);
        @(negedge clk);
        #1;
        check("R8 busy stays low 2", {71'd0, sync_busy}, 72'd0);

        // R9: config write during transfer is deferred
        cfg_write(2'd0, 64'h2B);
        sync_pulse();
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 64'h2C;
        @(negedge clk);
        cfg_we = 1'b0;
        wait_idle(n);
        do_wr(12'h02B, 8'hFF, D, 8'h5A, w);
        check("R9 staged address active", w, FULL);
        do_wr(12'h02C, 8'hFF, D, 8'h5A, w);
        check("R9 mid-transfer write deferred", w, PASS);
        wr_en = 1'b0;
        sync_pulse();
        wait_idle(n);
        do_wr(12'h02C, 8'hFF, D, 8'h5A, w);
        check("R9 applied after second sync", w, FULL);

        // R4: disarmed leaves target untouched
        wr_en = 1'b0;
        cfg_write(2'd3, 64'h0);
        sync_pulse();
        wait_idle(n);
        do_wr(12'h02C, 8'hFF, D, 8'h5A, w);
        check("R4 disarmed", w, PASS);
        wr_en = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule